// File: doc/BRIEF.md
# Proportional-to-Switch Channel Converter

This block turns a repeating proportional servo pulse, one pulse per frame, into a steady on/off control signal. Each pulse is timed in ticks from its rising edge to its falling edge. A pulse wider than a width threshold counts as an on command. The threshold sits between the short commanded width and the long commanded width. Pulses wider than a maximum plausible width count as corrupt and are discarded.

Every on command reloads a hold timer that runs longer than one frame. The raw decision stays on until that timer runs out. The timer therefore bridges the gap between frames and expires once long pulses stop arriving. A build-time option places a symmetric integrating filter after the raw decision. The filter is an up/down saturating counter with hysteresis, spanning a few frames. It gives similar delays for switching on and for switching off, and suppresses short disturbances.

The pulse input is a plain level signal and is synchronised inside the block. The output is a plain level. There is no stream traffic, so neither edge carries a valid/ready handshake and back-pressure does not arise.

Top module: `pcs_top`

## Requirements
- R1: After reset the switch output is low and the filter counter sits at zero.
- R2: A pulse of THRESH_TICKS+1 up to MAX_TICKS ticks is an on command. In the test configuration (one tick per clock, THRESH_TICKS=10, MAX_TICKS=30) widths 11 through 30 turn the output on within 8 clocks after the falling edge.
- R3: A pulse of THRESH_TICKS ticks or fewer (10 or fewer in the test configuration) does not turn the output on and does not reload the hold timer.
- R4: A pulse longer than MAX_TICKS ticks (31 or more in the test configuration) is ignored. It neither turns the output on nor extends an active hold.
- R5: After an on command the raw decision stays on for HOLD_TICKS ticks, and each later on command restarts the full hold. Pulses arriving every frame therefore keep the output on without a gap.
- R6: When no on command arrives for HOLD_TICKS ticks, the output goes low.
- R7: With the filter enabled, the output rises only after the filter counter has climbed to three quarters of INTEG_TICKS. The counter moves by at most one step per tick and saturates at INTEG_TICKS.
- R8: With the filter enabled, the output falls only after the counter has dropped to one quarter of INTEG_TICKS. Turn-off from saturation therefore takes about as many ticks as turn-on from zero.
- R9: The width measurement and all timers advance once every CLK_PER_TICK clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Proportional servo pulse, asynchronous level |
| switch_out | output | 1 | Steady on/off control output |

## Verification
The hardest condition to create from the ports is the hold running out while pulses are still arriving. Those pulses are either narrow or too wide, and neither kind may stretch the hold. The stimulus places such pulses inside an active hold window and checks the output just before and just after the expected expiry.

The exact width boundaries on both sides of the threshold and of the maximum are covered by a sweep. The sweep runs every width from 1 to 34 ticks and lets the hold expire between pulses, so each width starts from the off state.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Result of one completed pulse measurement.
  typedef struct packed {
    logic done;     // a falling edge closed a measurement this cycle
    logic is_on;    // width qualified as an on command
  } pcs_cmd_t;
endpackage

// File: rtl/pcs_tick_gen.sv
module pcs_tick_gen #(
  parameter int CLK_PER_TICK = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CLK_PER_TICK <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CLK_PER_TICK);
      localparam logic [DW-1:0] LAST = DW'(CLK_PER_TICK - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == LAST);

      a_r9_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/pcs_width_meas.sv
module pcs_width_meas
  import pcs_pkg::*;
#(
  parameter int THRESH_TICKS = 1000,
  parameter int MAX_TICKS    = 3000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     pulse_in,
  output pcs_cmd_t cmd
);
  localparam int CW = $clog2(MAX_TICKS + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_TICKS + 1);
  localparam logic [CW-1:0] THR = CW'(THRESH_TICKS);
  localparam logic [CW-1:0] MAXW = CW'(MAX_TICKS);

  logic sync1, sync2, sync3;
  logic rise, fall;
  logic [CW-1:0] width_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= pulse_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign rise = sync2 & ~sync3;
  assign fall = ~sync2 & sync3;

  always_ff @(posedge clk) begin
    if (!rst_n)
      width_q <= '0;
    else if (rise)
      width_q <= tick ? CW'(1) : '0;
    else if (sync2 && tick && width_q != SAT)
      width_q <= width_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0;
    end else begin
      cmd.done  <= fall;
      cmd.is_on <= fall && (width_q > THR) && (width_q <= MAXW);
    end
  end

  a_r4_width_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    width_q <= SAT);
  a_r2_cmd_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> cmd.done);
  a_r3_on_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.is_on |-> cmd.done);
endmodule

// File: rtl/pcs_hold_timer.sv
module pcs_hold_timer
  import pcs_pkg::*;
#(
  parameter int HOLD_TICKS = 70000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  pcs_cmd_t cmd,
  output logic     raw_on
);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLD_TICKS);

  logic [HW-1:0] remain_q;
  logic          reload;

  assign reload = cmd.done & cmd.is_on;

  always_ff @(posedge clk) begin
    if (!rst_n)
      remain_q <= '0;
    else if (reload)
      remain_q <= FULL;
    else if (tick && remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign raw_on = (remain_q != '0);

  a_r5_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q <= FULL);
  a_r5_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> remain_q == FULL);
  a_r6_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q != '0 && !reload && tick) |=> remain_q == $past(remain_q) - 1'b1);
endmodule

// File: rtl/pcs_integrator.sv
module pcs_integrator #(
  parameter int INTEG_TICKS = 70000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_on,
  output logic sw_q
);
  localparam int IW = $clog2(INTEG_TICKS + 1);
  localparam logic [IW-1:0] TOP    = IW'(INTEG_TICKS);
  localparam logic [IW-1:0] ON_LVL = IW'((INTEG_TICKS * 3) / 4);
  localparam logic [IW-1:0] OFF_LVL = IW'(INTEG_TICKS / 4);

  logic [IW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      acc_q <= '0;
    else if (tick) begin
      if (raw_on && acc_q != TOP)        acc_q <= acc_q + 1'b1;
      else if (!raw_on && acc_q != '0)   acc_q <= acc_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 sw_q <= 1'b0;
    else if (acc_q >= ON_LVL)   sw_q <= 1'b1;
    else if (acc_q <= OFF_LVL)  sw_q <= 1'b0;
  end

  a_r7_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= TOP);
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (acc_q == $past(acc_q)) || (acc_q == $past(acc_q) + 1'b1) ||
             (acc_q == $past(acc_q) - 1'b1));
  a_r8_off_below_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_q) |-> $past(acc_q) < ON_LVL);
  a_r7_on_above_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_q) |-> $past(acc_q) > OFF_LVL);
endmodule

// File: rtl/pcs_top.sv
module pcs_top
  import pcs_pkg::*;
#(
  parameter int CLK_PER_TICK = 50,
  parameter int THRESH_TICKS = 1000,
  parameter int MAX_TICKS    = 3000,
  parameter int HOLD_TICKS   = 70000,
  parameter int INTEG_TICKS  = 70000,
  parameter bit FILTER_EN    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic switch_out
);
  logic     tick;
  pcs_cmd_t cmd;
  logic     raw_on;

  pcs_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pcs_width_meas #(.THRESH_TICKS(THRESH_TICKS), .MAX_TICKS(MAX_TICKS)) u_meas (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pulse_in(pulse_in), .cmd(cmd)
  );

  pcs_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd), .raw_on(raw_on)
  );

  generate
    if (FILTER_EN) begin : g_filt
      pcs_integrator #(.INTEG_TICKS(INTEG_TICKS)) u_integ (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw_on(raw_on), .sw_q(switch_out)
      );
    end else begin : g_raw
      assign switch_out = raw_on;
    end
  endgenerate

  a_r1_reset_off: assert property (@(posedge clk)
    !rst_n |=> !switch_out);
endmodule

// File: tb/sim_pcs_top.sv
module sim_pcs_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p0 = 1'b0;
  logic p1 = 1'b0;
  logic sw0, sw1;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  // u0: one tick per clock, no filter
  pcs_top #(.CLK_PER_TICK(1), .THRESH_TICKS(10), .MAX_TICKS(30),
            .HOLD_TICKS(200), .INTEG_TICKS(60), .FILTER_EN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .pulse_in(p0), .switch_out(sw0)
  );
  // u1: two clocks per tick, filter on
  pcs_top #(.CLK_PER_TICK(2), .THRESH_TICKS(10), .MAX_TICKS(30),
            .HOLD_TICKS(200), .INTEG_TICKS(60), .FILTER_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pulse_in(p1), .switch_out(sw1)
  );

  task automatic check(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse0(input int w);
    p0 = 1'b1;
    wait_cyc(w);
    p0 = 1'b0;
  endtask

  task automatic pulse1(input int w);
    p1 = 1'b1;
    wait_cyc(w);
    p1 = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    check(sw0, 1'b0, "R1", "u0 output in reset");
    check(sw1, 1'b0, "R1", "u1 output in reset");
    rst_n = 1'b1;
    wait_cyc(3);
    check(sw0, 1'b0, "R1", "u0 output after reset");
    check(sw1, 1'b0, "R1", "u1 output after reset");

    // R3: at-threshold and short widths stay off
    pulse0(10); wait_cyc(8);
    check(sw0, 1'b0, "R3", "width 10 off");
    pulse0(5);  wait_cyc(8);
    check(sw0, 1'b0, "R3", "width 5 off");

    // R2 / R5 / R6 with width just above threshold
    pulse0(11); wait_cyc(8);
    check(sw0, 1'b1, "R2", "width 11 on");
    wait_cyc(182);
    check(sw0, 1'b1, "R5", "held before expiry");
    wait_cyc(25);
    check(sw0, 1'b0, "R6", "off after expiry");

    // R4 boundary
    pulse0(31); wait_cyc(8);
    check(sw0, 1'b0, "R4", "width 31 ignored");
    pulse0(30); wait_cyc(8);
    check(sw0, 1'b1, "R2", "width 30 on");
    wait_cyc(220);
    check(sw0, 1'b0, "R6", "off after width 30 hold");

    // R2/R3/R4 sweep of widths with expiry between
    for (int w = 1; w <= 34; w++) begin
      pulse0(w); wait_cyc(8);
      check(sw0, (w > 10 && w <= 30) ? 1'b1 : 1'b0, "R2", $sformatf("sweep width %0d", w));
      wait_cyc(210);
      check(sw0, 1'b0, "R6", $sformatf("sweep expiry width %0d", w));
    end

    // R5: long pulses every 120-cycle frame keep output on
    for (int f = 0; f < 4; f++) begin
      pulse0(20);
      wait_cyc(100);
      check(sw0, 1'b1, "R5", $sformatf("frame %0d held", f));
    end
    // then short pulses only: last long fall was 100 cycles ago
    pulse0(5); wait_cyc(85);   // elapsed 190
    check(sw0, 1'b1, "R3", "short pulse before expiry still on");
    wait_cyc(25);              // elapsed 215
    check(sw0, 1'b0, "R3", "short pulse did not refresh hold");
    wait_cyc(20);

    // R4: over-long pulse inside active hold does not extend it
    pulse0(20); wait_cyc(8);
    check(sw0, 1'b1, "R4", "on before invalid pulse");
    wait_cyc(92);
    pulse0(40);                // elapsed 140
    wait_cyc(75);              // elapsed 215
    check(sw0, 1'b0, "R4", "invalid pulse did not refresh hold");
    wait_cyc(20);

    // R9/R7/R8 on u1: two clocks per tick, filter
    pulse1(14); wait_cyc(150);
    check(sw1, 1'b0, "R9", "7-tick pulse off on divided clock");
    pulse1(40);
    wait_cyc(40);
    check(sw1, 1'b0, "R7", "filter still low early");
    wait_cyc(80);              // elapsed 120
    check(sw1, 1'b1, "R7", "filter on after climb");
    wait_cyc(330);             // elapsed 450
    check(sw1, 1'b1, "R8", "filter still on after raw drop");
    wait_cyc(110);             // elapsed 560
    check(sw1, 1'b0, "R8", "filter off after descent");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule